// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block joins two 16-bit buses, called A and B, with one storage path for each direction. Each path has three controls of its own: an active-low output enable, a latch enable and a data clock. While its latch enable is high, a path is transparent and the input word appears on the far port in the same cycle. While its latch enable is low, the path acts as an edge-triggered register. It captures the input on a low-to-high step of its data clock and otherwise holds what it stored.

The data clocks are treated as ordinary inputs sampled by the system clock. A rising step is seen when a sample is high and the previous sample was low. Each output port is presented as a data word plus a drive flag, and the flag stands for the tri-state enable. Storage clears on a synchronous active-low reset.

Top module: `xcvr_bidir`

## Requirements
- R1: When a direction's output enable (active low) is high, that direction's drive flag is 0, whatever the other inputs are. When it is low, the drive flag is 1.
- R2: With latch enable high, the output word equals the current input word in the same cycle, and the direction's data clock has no effect.
- R3: With latch enable low, a data clock sampled high at a system clock edge, after being sampled low at the previous edge, stores the input word at that edge. The output shows the stored word from then on.
- R4: With latch enable low and the data clock held low, the output keeps its stored word while the input word changes.
- R5: If latch enable falls while the data clock is already high, and the clock then stays high, the output keeps the word that was present on the last cycle latch enable was high.
- R6: The B-to-A path behaves like the A-to-B path but uses its own enables and clock. Activity on one direction never changes the other direction's output.
- R7: A synchronous reset (rst_n low) clears both stored words to zero. The data-clock history is set to high, so a clock held high when reset is released causes no capture.
- R8: The output enable does not affect storage. A word captured while the output is disabled appears once the output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 16 | Word arriving from bus A |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| le_ab | input | 1 | A-to-B latch enable |
| dclk_ab | input | 1 | A-to-B data clock |
| b_out | output | 16 | Word presented to bus B |
| b_drive | output | 1 | Bus B is driven when 1, high impedance when 0 |
| b_in | input | 16 | Word arriving from bus B |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| le_ba | input | 1 | B-to-A latch enable |
| dclk_ba | input | 1 | B-to-A data clock |
| a_out | output | 16 | Word presented to bus A |
| a_drive | output | 1 | Bus A is driven when 1, high impedance when 0 |

## Verification
On every cycle, the assertions check four behaviours: tracking while the latch is open, capture on a detected rising step, holding when no step is seen, and the drive flag following the enable. They also check the reset clearing storage. Other behaviours only the directed scenarios can show: that a latch enable falling while the clock is high leaves the word frozen, that a clock held high across reset release does not capture, and that one direction never disturbs the other. Each of these depends on a specific history of the inputs, not on a relation within one or two cycles.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    parameter int unsigned XCVR_DW_DEFAULT = 16;
    localparam int unsigned XCVR_NUM_DIRS  = 2;

    typedef enum logic {
        DIR_AB = 1'b0,
        DIR_BA = 1'b1
    } xcvr_dir_e;

    typedef struct packed {
        logic prev;
    } xcvr_edge_st;

endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);

    xcvr_edge_st st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig;
        if (!rst_n) begin
            st_d.prev = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rise = rst_n && sig && !st_q.prev;

endmodule

// File: rtl/xcvr_stage.sv
module xcvr_stage #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          le,
    input  logic          rise,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] q
);

    typedef struct packed {
        logic [DW-1:0] word;
    } stage_st;

    stage_st st_d, st_q;
    logic    load;

    always_comb begin
        load = le || rise;
        st_d = st_q;
        if (!rst_n) begin
            st_d.word = '0;
        end else if (load) begin
            st_d.word = din;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.word;

    a_r3_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && rise) |=> (q == $past(din)));

    a_r4_hold_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !rise) |=> $stable(q));

    a_r2_track_while_open: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> (q == $past(din)));

    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          oe_n,
    input  logic          le,
    input  logic          dclk,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          drive
);

    logic          rise;
    logic [DW-1:0] held;

    xcvr_edge_det u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (dclk),
        .rise (rise)
    );

    xcvr_stage #(.DW(DW)) u_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .le   (le),
        .rise (rise),
        .din  (din),
        .q    (held)
    );

    always_comb begin
        dout  = le ? din : held;
        drive = !oe_n;
    end

endmodule

// File: rtl/xcvr_bidir.sv
module xcvr_bidir
    import xcvr_pkg::*;
#(
    parameter int unsigned DW = XCVR_DW_DEFAULT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] a_in,
    input  logic          oe_ab_n,
    input  logic          le_ab,
    input  logic          dclk_ab,
    output logic [DW-1:0] b_out,
    output logic          b_drive,
    input  logic [DW-1:0] b_in,
    input  logic          oe_ba_n,
    input  logic          le_ba,
    input  logic          dclk_ba,
    output logic [DW-1:0] a_out,
    output logic          a_drive
);

    localparam int unsigned ND = XCVR_NUM_DIRS;

    logic [ND-1:0][DW-1:0] din_v, dout_v;
    logic [ND-1:0]         oe_n_v, le_v, dclk_v, drive_v;

    always_comb begin
        din_v[DIR_AB]  = a_in;
        oe_n_v[DIR_AB] = oe_ab_n;
        le_v[DIR_AB]   = le_ab;
        dclk_v[DIR_AB] = dclk_ab;
        din_v[DIR_BA]  = b_in;
        oe_n_v[DIR_BA] = oe_ba_n;
        le_v[DIR_BA]   = le_ba;
        dclk_v[DIR_BA] = dclk_ba;
    end

    for (genvar g = 0; g < ND; g++) begin : g_dir
        xcvr_path #(.DW(DW)) u_path (
            .clk  (clk),
            .rst_n(rst_n),
            .oe_n (oe_n_v[g]),
            .le   (le_v[g]),
            .dclk (dclk_v[g]),
            .din  (din_v[g]),
            .dout (dout_v[g]),
            .drive(drive_v[g])
        );
    end

    assign b_out   = dout_v[DIR_AB];
    assign b_drive = drive_v[DIR_AB];
    assign a_out   = dout_v[DIR_BA];
    assign a_drive = drive_v[DIR_BA];

    a_r1_b_drive_follows_oe: assert property (@(posedge clk) disable iff (!rst_n)
        b_drive == !oe_ab_n);

    a_r1_a_drive_follows_oe: assert property (@(posedge clk) disable iff (!rst_n)
        a_drive == !oe_ba_n);

    a_r2_b_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        le_ab |-> (b_out == a_in));

    a_r6_a_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        le_ba |-> (a_out == b_in));

endmodule

// File: tb/xcvr_bidir_tb_top.sv
module xcvr_bidir_tb_top;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] a_in, b_in;
    logic          oe_ab_n, le_ab, dclk_ab;
    logic          oe_ba_n, le_ba, dclk_ba;
    logic [DW-1:0] b_out, a_out;
    logic          b_drive, a_drive;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    xcvr_bidir #(.DW(DW)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_in   (a_in),
        .oe_ab_n(oe_ab_n),
        .le_ab  (le_ab),
        .dclk_ab(dclk_ab),
        .b_out  (b_out),
        .b_drive(b_drive),
        .b_in   (b_in),
        .oe_ba_n(oe_ba_n),
        .le_ba  (le_ba),
        .dclk_ba(dclk_ba),
        .a_out  (a_out),
        .a_drive(a_drive)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        a_in = 16'hFFFF; b_in = 16'hFFFF;
        oe_ab_n = 1'b0; oe_ba_n = 1'b0;
        le_ab = 1'b0; le_ba = 1'b0;
        dclk_ab = 1'b1; dclk_ba = 1'b1;
        repeat (3) step();
        check("R7 reset b_out", b_out, 16'h0);
        check("R7 reset a_out", a_out, 16'h0);
        rst_n = 1'b1;
        step();
        step();
        check("R7 no capture after release b", b_out, 16'h0);
        check("R7 no capture after release a", a_out, 16'h0);
    endtask

    task automatic t_oe();
        oe_ab_n = 1'b1; #1;
        check("R1 b_drive off", b_drive, 1'b0);
        check("R1 a_drive on", a_drive, 1'b1);
        oe_ba_n = 1'b1; le_ab = 1'b1; dclk_ab = 1'b0; #1;
        check("R1 a_drive off", a_drive, 1'b0);
        check("R1 b_drive off any ctl", b_drive, 1'b0);
        oe_ab_n = 1'b0; oe_ba_n = 1'b0; le_ab = 1'b0; dclk_ab = 1'b1;
        step();
        check("R1 b_drive on", b_drive, 1'b1);
    endtask

    task automatic t_transparent();
        le_ab = 1'b1;
        a_in = 16'h1234; #1;
        check("R2 follow 1", b_out, 16'h1234);
        a_in = 16'hBEEF; dclk_ab = 1'b0; #1;
        check("R2 follow 2", b_out, 16'hBEEF);
        step();
        dclk_ab = 1'b1; a_in = 16'h0F0F;
        step();
        check("R2 clock ignored", b_out, 16'h0F0F);
    endtask

    task automatic t_le_fall_clk_high();
        le_ab = 1'b1; dclk_ab = 1'b1; a_in = 16'hA5A5;
        step();
        le_ab = 1'b0; a_in = 16'h5A5A; #1;
        check("R5 freeze at le fall", b_out, 16'hA5A5);
        repeat (3) step();
        check("R5 hold while clk high", b_out, 16'hA5A5);
    endtask

    task automatic t_capture();
        dclk_ab = 1'b0; a_in = 16'h1111;
        step();
        check("R4 hold clk low", b_out, 16'hA5A5);
        a_in = 16'hC0DE; dclk_ab = 1'b1;
        step();
        check("R3 capture on rise", b_out, 16'hC0DE);
        a_in = 16'h2222;
        step();
        check("R5 no recapture clk high", b_out, 16'hC0DE);
        dclk_ab = 1'b0; a_in = 16'h3333;
        repeat (3) step();
        check("R4 hold after fall", b_out, 16'hC0DE);
    endtask

    task automatic t_oe_storage();
        oe_ab_n = 1'b1; a_in = 16'h7E57; dclk_ab = 1'b1;
        step();
        dclk_ab = 1'b0; a_in = 16'h0000;
        step();
        check("R8 drive off while capture", b_drive, 1'b0);
        oe_ab_n = 1'b0; #1;
        check("R8 captured while disabled", b_out, 16'h7E57);
    endtask

    task automatic t_independent();
        logic [DW-1:0] b_before;
        le_ba = 1'b0; dclk_ba = 1'b0; b_in = 16'h4444;
        step();
        b_in = 16'h9876; dclk_ba = 1'b1;
        step();
        check("R6 B-to-A capture", a_out, 16'h9876);
        b_before = b_out;
        check("R6 A-to-B untouched", b_out, 16'h7E57);
        b_in = 16'h0001; le_ba = 1'b1; dclk_ba = 1'b0;
        step();
        check("R6 B-to-A transparent", a_out, 16'h0001);
        check("R6 b_out unchanged", b_out, b_before);
        le_ba = 1'b0;
        step();
        a_in = 16'h6666; dclk_ab = 1'b1;
        step();
        check("R6 A-to-B capture", b_out, 16'h6666);
        check("R6 a_out unchanged by A side", a_out, 16'h0001);
        oe_ab_n = 1'b1; #1;
        check("R6 a_drive unaffected", a_drive, 1'b1);
        oe_ab_n = 1'b0;
    endtask

    initial begin
        t_reset();
        t_oe();
        t_transparent();
        t_le_fall_clk_high();
        t_capture();
        t_oe_storage();
        t_independent();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule